// File: doc/BRIEF.md
# Polled UART register front end with FIFO status and sticky errors

This block is the register side of a UART that software drives purely by polling. It holds a receive FIFO fed by the serial shifter and a transmit FIFO that drains into the shifter. It also keeps a sticky record of receive-line faults. A small word-addressed register port gives software access to three control registers, a packed FIFO status word, a clear-on-read error word, a transmit-hold write port and a receive-buffer read port. The shifter, interrupts, DMA and modem lines live elsewhere.

Software reads the status word to decide whether a byte is waiting or whether there is room to send. The receive occupancy field is only as wide as the FIFO depth's address, so a completely full receive FIFO shows a count of zero. Pollers must therefore test the receive-full flag as well as the count. Two summary outputs split the error word: one reflects only the break condition, which matters to a transmit poll. The other reflects any receive fault, for a receive poll.

Register map (3-bit word address): 0 line control (8 bits; 0x03 selects 8 data bits, no parity, one stop bit), 1 FIFO control (8 bits; bit 0 enables the FIFOs), 2 general control (32 bits), 3 FIFO status, 4 error status, 5 transmit hold (write only), 6 receive buffer (read only). Address 7 reads as zero.

Top module: `uart_poll_regs`

## Requirements
- R1: The status word (address 3) holds the receive occupancy modulo RX_DEPTH in bits [7:0], the receive-full flag in bit 8 and the transmit-full flag in bit 24, with every other bit zero; with RX_DEPTH=64 a full receive FIFO reads 0x0000_0100.
- R2: Bytes presented with rx_valid_i are returned in arrival order by reads of address 6, each read removing one byte; a read of address 6 with the receive FIFO empty returns 0 and changes nothing.
- R3: A byte that arrives while the receive FIFO holds RX_DEPTH bytes is discarded and sets the overrun bit (bit 0) of the error word; this applies even when a receive-buffer read happens in the same cycle.
- R4: The error word (address 4) has break in bit 3, framing in bit 2, parity in bit 1 and overrun in bit 0; each bit stays set until the word is read, a read returns the value before clearing, and an event arriving in the same cycle as that read stays set afterwards.
- R5: tx_err_o is high exactly when the break bit is set; rx_err_o is high when any of the four error bits is set.
- R6: A write to address 5 while the transmit FIFO holds TX_DEPTH bytes is discarded, and status bit 24 is high while it is full.
- R7: tx_valid_o is high whenever the transmit FIFO is non-empty, with tx_data_o the oldest byte; the byte is removed in a cycle where tx_valid_o and tx_ready_i are both high, and is otherwise held unchanged.
- R8: While FIFO control bit 0 is 0 (its reset value), both FIFOs are emptied and kept empty: received bytes and transmit-hold writes are discarded, and no overrun is raised.
- R9: The three control registers reset to zero and read back what was written, line and FIFO control keeping only bits [7:0]; writes to addresses 3, 4 and 6 have no effect, and reads of 5 and 7 return zero.
- R10: Read data appears on rdata_o in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Access is a write when high |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rx_valid_i | input | 1 | Received byte from the shifter |
| rx_data_i | input | 8 | Received byte value |
| brk_i | input | 1 | Break detected pulse |
| frame_err_i | input | 1 | Framing error pulse |
| parity_err_i | input | 1 | Parity error pulse |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | 8 | Transmit byte to the shifter |
| tx_ready_i | input | 1 | Shifter accepts the transmit byte |
| tx_err_o | output | 1 | Break flag summary for transmit polling |
| rx_err_o | output | 1 | Any-error summary for receive polling |

## Verification
The hardest state to reach is a receive FIFO holding exactly its full depth, where the count field wraps to zero. In that state an incoming byte must be dropped with an overrun, even while a read frees a slot in the same cycle. The stimulus fills the FIFO with 64 distinct bytes and then offers one more. Later it offers a byte in the same cycle as a receive-buffer read. After each case it drains every entry to show which byte survived. The error word is also driven with a break pulse in the very cycle it is read, so that the set-over-clear ordering becomes visible.

// File: rtl/uart_poll_pkg.sv
package uart_poll_pkg;
  typedef enum logic [2:0] {
    REG_LINE = 3'd0,
    REG_FIFO = 3'd1,
    REG_CTRL = 3'd2,
    REG_STAT = 3'd3,
    REG_ERR  = 3'd4,
    REG_TXH  = 3'd5,
    REG_RXB  = 3'd6,
    REG_NONE = 3'd7
  } reg_addr_e;

  localparam int unsigned STAT_RXFULL_BIT = 8;
  localparam int unsigned STAT_TXFULL_BIT = 24;

  localparam int unsigned ERR_OVR = 0;
  localparam int unsigned ERR_PAR = 1;
  localparam int unsigned ERR_FRM = 2;
  localparam int unsigned ERR_BRK = 3;
  localparam int unsigned ERR_W   = 4;
endpackage

// File: rtl/uart_poll_fifo.sv
module uart_poll_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && !flush_i && (cnt_q != FULL_CNT);
  assign do_pop  = pop_i  && !flush_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);  // R1
  AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == FULL_CNT) && push_i && !pop_i && !flush_i |=> count_o == FULL_CNT);  // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_o == '0);  // R8
endmodule

// File: rtl/uart_poll_err.sv
module uart_poll_err #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] err_o
);
  logic [N-1:0] err_q;

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (clr_i ? '0 : err_q) | set_i;
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (err_o & $past(err_o)) == $past(err_o));  // R4
  AST_ERR_SET_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_o & ~$past(set_i)) == '0);  // R4
endmodule

// File: rtl/uart_poll_regs.sv
module uart_poll_regs
  import uart_poll_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 64,
  parameter int unsigned TX_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        brk_i,
  input  logic        frame_err_i,
  input  logic        parity_err_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  output logic        tx_err_o,
  output logic        rx_err_o
);
  localparam int unsigned RX_PW = $clog2(RX_DEPTH);
  localparam int unsigned RX_CW = RX_PW + 1;
  localparam int unsigned TX_CW = $clog2(TX_DEPTH) + 1;
  localparam logic [RX_CW-1:0] RX_FULL_CNT = RX_CW'(RX_DEPTH);
  localparam logic [TX_CW-1:0] TX_FULL_CNT = TX_CW'(TX_DEPTH);

  reg_addr_e          sel;
  logic               rd, wr;
  logic [7:0]         line_q, fifo_q;
  logic [31:0]        ctrl_q, rdata_q, rd_val, stat;
  logic               fifo_en;
  logic [RX_CW-1:0]   rx_cnt;
  logic [TX_CW-1:0]   tx_cnt;
  logic [7:0]         rx_head;
  logic               rx_full, tx_full;
  logic               rx_push, rx_pop, tx_push, tx_pop, overrun;
  logic [ERR_W-1:0]   err_set, err;

  assign sel = reg_addr_e'(addr_i);
  assign rd  = req_i && !we_i;
  assign wr  = req_i && we_i;

  assign fifo_en = fifo_q[0];
  assign rx_full = (rx_cnt == RX_FULL_CNT);
  assign tx_full = (tx_cnt == TX_FULL_CNT);

  assign rx_push = rx_valid_i && fifo_en && !rx_full;
  assign overrun = rx_valid_i && fifo_en && rx_full;
  assign rx_pop  = rd && (sel == REG_RXB);
  assign tx_push = wr && (sel == REG_TXH) && !tx_full;
  assign tx_pop  = tx_valid_o && tx_ready_i;

  uart_poll_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!fifo_en),
    .push_i  (rx_push),
    .wdata_i (rx_data_i),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt)
  );

  uart_poll_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!fifo_en),
    .push_i  (tx_push),
    .wdata_i (wdata_i[7:0]),
    .pop_i   (tx_pop),
    .rdata_o (tx_data_o),
    .count_o (tx_cnt)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_BRK] = brk_i;
    err_set[ERR_FRM] = frame_err_i;
    err_set[ERR_PAR] = parity_err_i;
    err_set[ERR_OVR] = overrun;
  end

  uart_poll_err #(.N(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (rd && (sel == REG_ERR)),
    .err_o  (err)
  );

  assign tx_valid_o = (tx_cnt != '0);
  assign tx_err_o   = err[ERR_BRK];
  assign rx_err_o   = |err;

  // count field wraps at full depth; full is reported separately
  always_comb begin
    stat                  = '0;
    stat[RX_PW-1:0]       = rx_cnt[RX_PW-1:0];
    stat[STAT_RXFULL_BIT] = rx_full;
    stat[STAT_TXFULL_BIT] = tx_full;
  end

  always_comb begin
    case (sel)
      REG_LINE: rd_val = {24'd0, line_q};
      REG_FIFO: rd_val = {24'd0, fifo_q};
      REG_CTRL: rd_val = ctrl_q;
      REG_STAT: rd_val = stat;
      REG_ERR:  rd_val = {{(32-ERR_W){1'b0}}, err};
      REG_RXB:  rd_val = (rx_cnt != '0) ? {24'd0, rx_head} : 32'd0;
      default:  rd_val = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      fifo_q  <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (rd) rdata_q <= rd_val;
      if (wr) begin
        case (sel)
          REG_LINE: line_q <= wdata_i[7:0];
          REG_FIFO: fifo_q <= wdata_i[7:0];
          REG_CTRL: ctrl_q <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;

  AST_OVERRUN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && fifo_en && rx_full |=> err[ERR_OVR]);  // R3
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop && (rx_cnt == '0) |=> rdata_o == 32'd0);  // R2
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && fifo_en |=> tx_valid_o && $stable(tx_data_o));  // R7
  AST_TX_FULL_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full && !tx_ready_i && fifo_en |=> tx_full);  // R6
  AST_BREAK_IMPLIES_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> rx_err_o);  // R5
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));  // R10
endmodule

// File: tb/uart_poll_regs_tb.sv
`timescale 1ns/1ps
module uart_poll_regs_tb;
  localparam int RXD = 64;
  localparam int TXD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        brk = 1'b0, frm = 1'b0, par = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        tx_err, rx_err;

  always #2 clk = ~clk;

  uart_poll_regs #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .brk_i(brk), .frame_err_i(frm), .parity_err_i(par), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_ready_i(tx_ready), .tx_err_o(tx_err), .rx_err_o(rx_err)
  );

  int n_chk = 0, n_fail = 0;
  string rd_tag = "R10";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0]  rxq[$];
  logic [7:0]  txq[$];
  logic [7:0]  m_line = '0, m_fifo = '0;
  logic [31:0] m_ctrl = '0, m_rdata = '0;
  logic [3:0]  m_err = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      m_line = '0; m_fifo = '0; m_ctrl = '0; m_rdata = '0; m_err = '0;
    end else begin
      automatic bit en = m_fifo[0];
      automatic int rxn = rxq.size();
      automatic int txn = txq.size();
      automatic bit rxf = (rxn == RXD);
      automatic bit txf = (txn == TXD);
      automatic bit rd = req && !we;
      automatic bit wr = req && we;
      automatic logic [3:0] ev = {brk, frm, par, rx_valid && en && rxf};
      if (rd) begin
        case (addr)
          3'd0: m_rdata = {24'd0, m_line};
          3'd1: m_rdata = {24'd0, m_fifo};
          3'd2: m_rdata = m_ctrl;
          3'd3: m_rdata = {7'd0, txf, 15'd0, rxf, 8'(rxn % RXD)};
          3'd4: m_rdata = {28'd0, m_err};
          3'd6: m_rdata = (rxn > 0) ? {24'd0, rxq[0]} : 32'd0;
          default: m_rdata = 32'd0;
        endcase
      end
      m_err = ((rd && addr == 3'd4) ? 4'd0 : m_err) | ev;
      if (!en) begin
        rxq.delete(); txq.delete();
      end else begin
        if (rd && addr == 3'd6 && rxn > 0) void'(rxq.pop_front());
        if (rx_valid && !rxf) rxq.push_back(rx_data);
        if (txn > 0 && tx_ready) void'(txq.pop_front());
        if (wr && addr == 3'd5 && !txf) txq.push_back(wdata[7:0]);
      end
      if (wr) begin
        case (addr)
          3'd0: m_line = wdata[7:0];
          3'd1: m_fifo = wdata[7:0];
          3'd2: m_ctrl = wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit mv = (txq.size() > 0);
      chk(rd_tag, rdata, m_rdata);
      chk("R7", {23'd0, tx_valid, tx_valid ? tx_data : 8'd0}, {23'd0, mv, mv ? txq[0] : 8'd0});
      chk("R5", {30'd0, tx_err, rx_err}, {30'd0, m_err[3], |m_err});
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    req = 1'b1; we = 1'b0; addr = a; rd_tag = tag;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_err(input logic b, input logic f, input logic p);
    brk = b; frm = f; par = p;
    @(negedge clk);
    brk = 1'b0; frm = 1'b0; par = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R9 reset values, R1 empty status
    for (int a = 0; a < 8; a++) begin
      rd_reg(3'(a), "R9");
      chk("R9", rdata, 32'd0);
    end

    // R8: FIFOs disabled after reset
    rx_byte(8'h11); rx_byte(8'h22);
    wr_reg(3'd5, 32'h55);
    rd_reg(3'd3, "R8"); chk("R8", rdata, 32'd0);
    rd_reg(3'd4, "R8"); chk("R8", rdata, 32'd0);
    chk("R8", {31'd0, tx_valid}, 32'd0);

    // R9 control registers
    wr_reg(3'd1, 32'h1);
    wr_reg(3'd0, 32'h3);
    wr_reg(3'd2, 32'hDEAD_BEEF);
    rd_reg(3'd0, "R9"); chk("R9", rdata, 32'h3);
    rd_reg(3'd2, "R9"); chk("R9", rdata, 32'hDEAD_BEEF);
    wr_reg(3'd0, 32'h1FF);
    rd_reg(3'd0, "R9"); chk("R9", rdata, 32'hFF);
    wr_reg(3'd3, 32'hFFFF_FFFF);
    wr_reg(3'd4, 32'hF);
    rd_reg(3'd3, "R9"); chk("R9", rdata, 32'd0);
    rd_reg(3'd4, "R9"); chk("R9", rdata, 32'd0);

    // R2 ordering and empty read
    for (int i = 0; i < 5; i++) rx_byte(8'h10 + 8'(i));
    rd_reg(3'd3, "R1"); chk("R1", rdata, 32'd5);
    for (int i = 0; i < 5; i++) begin
      rd_reg(3'd6, "R2"); chk("R2", rdata, 32'h10 + 32'(i));
    end
    rd_reg(3'd6, "R2"); chk("R2", rdata, 32'd0);
    rd_reg(3'd3, "R2"); chk("R2", rdata, 32'd0);

    // R1 full wrap, R3 overrun
    for (int i = 0; i < RXD; i++) rx_byte(8'(i + 1));
    rd_reg(3'd3, "R1"); chk("R1", rdata, 32'h100);
    rx_byte(8'hEE);
    chk("R3", {30'd0, tx_err, rx_err}, 32'd1);
    rd_reg(3'd4, "R3"); chk("R3", rdata, 32'h1);
    rd_reg(3'd4, "R4"); chk("R4", rdata, 32'h0);
    for (int i = 0; i < RXD; i++) begin
      rd_reg(3'd6, "R3"); chk("R3", rdata, 32'(i + 1));
    end
    rd_reg(3'd6, "R3"); chk("R3", rdata, 32'd0);

    // R3: arrival at full with a same-cycle read
    for (int i = 0; i < RXD; i++) rx_byte(8'(i + 2));
    rx_valid = 1'b1; rx_data = 8'h77; req = 1'b1; we = 1'b0; addr = 3'd6; rd_tag = "R3";
    @(negedge clk);
    rx_valid = 1'b0; req = 1'b0;
    chk("R3", rdata, 32'h2);
    rd_reg(3'd3, "R3"); chk("R3", rdata, 32'h3F);
    rd_reg(3'd4, "R3"); chk("R3", rdata, 32'h1);
    wr_reg(3'd1, 32'h0);
    idle(1);
    wr_reg(3'd1, 32'h1);

    // R4 / R5 error word and summaries
    pulse_err(1'b1, 1'b0, 1'b0);
    chk("R5", {30'd0, tx_err, rx_err}, 32'h3);
    rd_reg(3'd4, "R4"); chk("R4", rdata, 32'h8);
    pulse_err(1'b0, 1'b1, 1'b0);
    chk("R5", {30'd0, tx_err, rx_err}, 32'h1);
    pulse_err(1'b0, 1'b0, 1'b1);
    idle(2);
    brk = 1'b1; req = 1'b1; we = 1'b0; addr = 3'd4; rd_tag = "R4";
    @(negedge clk);
    brk = 1'b0; req = 1'b0;
    chk("R4", rdata, 32'h6);
    chk("R5", {30'd0, tx_err, rx_err}, 32'h3);
    rd_reg(3'd4, "R4"); chk("R4", rdata, 32'h8);

    // R6 / R7 transmit path
    tx_ready = 1'b0;
    for (int i = 0; i < TXD + 1; i++) wr_reg(3'd5, 32'hA0 + 32'(i));
    rd_reg(3'd3, "R6"); chk("R6", rdata, 32'h0100_0000);
    idle(2);
    chk("R7", {23'd0, tx_valid, tx_data}, {23'd1, 8'hA0});
    tx_ready = 1'b1;
    for (int i = 0; i < TXD; i++) begin
      chk("R7", {23'd0, tx_valid, tx_data}, {23'd1, 8'hA0 + 8'(i)});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R6", {31'd0, tx_valid}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      tx_ready = 1'(i & 1);
      wr_reg(3'd5, 32'hC0 + 32'(i));
    end
    for (int i = 0; i < 6; i++) begin
      tx_ready = 1'(i & 1);
      @(negedge clk);
    end
    tx_ready = 1'b0;

    // R8 flush with contents present
    for (int i = 0; i < 3; i++) wr_reg(3'd5, 32'h30 + 32'(i));
    rx_byte(8'h41); rx_byte(8'h42);
    wr_reg(3'd1, 32'h0);
    idle(2);
    rx_byte(8'h43);
    wr_reg(3'd5, 32'h99);
    chk("R8", {31'd0, tx_valid}, 32'd0);
    wr_reg(3'd1, 32'h1);
    rd_reg(3'd3, "R8"); chk("R8", rdata, 32'd0);
    rd_reg(3'd4, "R8"); chk("R8", rdata, 32'd0);

    // R10 read data hold
    rd_reg(3'd2, "R10");
    saved = rdata;
    chk("R10", saved, 32'hDEAD_BEEF);
    rx_byte(8'h5A);
    idle(3);
    chk("R10", rdata, saved);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule